// File: doc/BRIEF.md
# Alignment-Driven Copy Beat Sizer

This block splits a byte copy into bus beats for a memory-to-memory mover. A start pulse loads a byte address and a byte count. The block then offers one beat at a time, giving each beat an address and a width of 8, 16 or 32 bits. The width is the widest one that the current address alignment allows and that does not run past the bytes still owed. No element size, whether for source, destination or data, enters the decision. The caller does not have to choose a transfer width. An unaligned head and tail are handled with narrow beats, and the aligned middle runs at full word width.

The beat output is a valid/ready stream. `beat_valid` stays high while bytes remain. A beat is accepted in a cycle where both `beat_valid` and `beat_ready` are high. While `beat_ready` is low, the offered address and size are held unchanged, and the sink may stall for any number of cycles. `start` and `done` are plain control pins. The block moves no data and knows nothing of bus protocol or arbitration.

Top module: `copy_beat_sizer`

## Requirements
- R1: After reset, `beat_valid` and `done` are both 0.
- R2: `beat_size` encodes the beat width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. The width is chosen as follows:
  - It is 4 bytes when address bits [1:0] are 00 and at least 4 bytes remain.
  - Otherwise it is 2 bytes when address bit 0 is 0 and at least 2 bytes remain.
  - Otherwise it is 1 byte.
- R3: The beat address rises by the beat's byte width, and the remaining count falls by the same amount, only in a cycle where `beat_valid` and `beat_ready` are both high. While `beat_ready` is low, `beat_addr` and `beat_size` hold.
- R4: The accepted beats add up to exactly the loaded count. `done` is high for exactly one cycle: the cycle after the last beat is accepted. `beat_valid` is low in that cycle.
- R5: A start with a count of 0 produces no beat. `done` is high in the cycle after the start.
- R6: A `start` that arrives while beats are still owed is ignored. The beat address and size on offer are unchanged, and the copy in flight completes with its original length.
- R7: Every offered beat is aligned to its own width and never exceeds the bytes still owed.
- R8: Starting at address 0x1 with a count of 10, the beats are 1, 2, 4, 2 and 1 bytes, at addresses 0x1, 0x2, 0x4, 0x8 and 0xA.
- R9: The first beat is offered in the cycle after the start is taken, at the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load `start_addr` and `byte_cnt` when idle |
| start_addr | input | ADDR_W | First byte address of the copy |
| byte_cnt | input | CNT_W | Number of bytes to copy |
| beat_valid | output | 1 | A beat is on offer |
| beat_ready | input | 1 | Sink accepts the offered beat |
| beat_addr | output | ADDR_W | Address of the offered beat |
| beat_size | output | 2 | Beat width code (0 = 8, 1 = 16, 2 = 32 bits) |
| done | output | 1 | One-cycle pulse when the copy finishes |

## Verification
The bench goes after the following corner cases:
- **Unaligned start with a short tail** (address 0x1, count 10). A sizer that looked only at alignment would issue a word beat over the last three bytes. One that looked only at length would issue a misaligned word at 0x1.
- **Sink stalls on every third cycle.** A design that advanced its cursor without a handshake would skip addresses.
- **Counts of 0, 1 and 3.** A wrong empty-copy path would hang with no `done`, or would emit a phantom beat.
- **A second start during a stalled copy.** A design that reloaded on it would jump to the new address.

// File: rtl/copy_sizer_pkg.sv
package copy_sizer_pkg;
  typedef enum logic [1:0] {
    BEAT_B = 2'd0,
    BEAT_H = 2'd1,
    BEAT_W = 2'd2
  } beat_sz_e;

  localparam int BEAT_BYTES_W = 3;
endpackage

// File: rtl/beat_width_pick.sv
module beat_width_pick
  import copy_sizer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [1:0]              addr_lo,
  input  logic [CNT_W-1:0]        rem,
  output beat_sz_e                sz,
  output logic [BEAT_BYTES_W-1:0] nbytes
);
  logic ge4, ge2;

  assign ge4 = (rem >= CNT_W'(4));
  assign ge2 = (rem >= CNT_W'(2));

  always_comb begin
    if (addr_lo == 2'b00 && ge4) begin
      sz     = BEAT_W;
      nbytes = BEAT_BYTES_W'(4);
    end else if (!addr_lo[0] && ge2) begin
      sz     = BEAT_H;
      nbytes = BEAT_BYTES_W'(2);
    end else begin
      sz     = BEAT_B;
      nbytes = BEAT_BYTES_W'(1);
    end
  end
endmodule

// File: rtl/copy_cursor.sv
module copy_cursor
  import copy_sizer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [ADDR_W-1:0]       load_addr,
  input  logic [CNT_W-1:0]        load_cnt,
  input  logic                    step,
  input  logic [BEAT_BYTES_W-1:0] step_bytes,
  output logic [ADDR_W-1:0]       cur_addr,
  output logic [CNT_W-1:0]        rem,
  output logic                    busy
);
  localparam int APAD = ADDR_W - BEAT_BYTES_W;
  localparam int CPAD = CNT_W - BEAT_BYTES_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      rem      <= '0;
    end else if (load) begin
      cur_addr <= load_addr;
      rem      <= load_cnt;
    end else if (step) begin
      cur_addr <= cur_addr + {{APAD{1'b0}}, step_bytes};
      rem      <= rem - {{CPAD{1'b0}}, step_bytes};
    end
  end

  assign busy = (rem != '0);
endmodule

// File: rtl/copy_beat_sizer.sv
module copy_beat_sizer
  import copy_sizer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  byte_cnt,
  output logic              beat_valid,
  input  logic              beat_ready,
  output logic [ADDR_W-1:0] beat_addr,
  output logic [1:0]        beat_size,
  output logic              done
);
  localparam int CPAD = CNT_W - BEAT_BYTES_W;

  logic                    busy;
  logic [CNT_W-1:0]        rem;
  logic                    take_start;
  logic                    step;
  logic                    last_step;
  beat_sz_e                sz;
  logic [BEAT_BYTES_W-1:0] nbytes;
  logic                    done_q;

  assign take_start = start && !busy;
  assign step       = busy && beat_ready;
  assign last_step  = step && (rem == {{CPAD{1'b0}}, nbytes});

  copy_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (take_start),
    .load_addr  (start_addr),
    .load_cnt   (byte_cnt),
    .step       (step),
    .step_bytes (nbytes),
    .cur_addr   (beat_addr),
    .rem        (rem),
    .busy       (busy)
  );

  beat_width_pick #(.CNT_W(CNT_W)) u_pick (
    .addr_lo (beat_addr[1:0]),
    .rem     (rem),
    .sz      (sz),
    .nbytes  (nbytes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= (take_start && byte_cnt == '0) || last_step;
  end

  assign beat_valid = busy;
  assign beat_size  = sz;
  assign done       = done_q;
endmodule

// File: rtl/copy_beat_sizer_chk.sv
module copy_beat_sizer_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [CNT_W-1:0]  byte_cnt,
  input logic              beat_valid,
  input logic              beat_ready,
  input logic [ADDR_W-1:0] beat_addr,
  input logic [1:0]        beat_size,
  input logic              done,
  input logic [CNT_W-1:0]  rem_left
);
  logic [CNT_W-1:0] sz_bytes;
  assign sz_bytes = (beat_size == 2'd2) ? CNT_W'(4) :
                    (beat_size == 2'd1) ? CNT_W'(2) : CNT_W'(1);

  // R2
  size_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> beat_size != 2'd3);

  // R7
  align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> !(beat_size == 2'd2 && beat_addr[1:0] != 2'b00) &&
                   !(beat_size == 2'd1 && beat_addr[0]));

  // R7
  fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid |-> sz_bytes <= rem_left);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_ready |=> beat_valid && $stable(beat_addr) && $stable(beat_size));

  // R5
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !beat_valid && byte_cnt == '0 |=> done && !beat_valid);

  // R4
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !beat_valid);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind copy_beat_sizer copy_beat_sizer_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .byte_cnt   (byte_cnt),
  .beat_valid (beat_valid),
  .beat_ready (beat_ready),
  .beat_addr  (beat_addr),
  .beat_size  (beat_size),
  .done       (done),
  .rem_left   (rem)
);

// File: tb/copy_beat_sizer_tb.sv
module copy_beat_sizer_tb;
  localparam int AW = 32;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] byte_cnt = '0;
  logic          beat_ready = 1'b0;
  logic          beat_valid;
  logic [AW-1:0] beat_addr;
  logic [1:0]    beat_size;
  logic          done;

  int total = 0;
  int bad = 0;
  int seq[$];

  copy_beat_sizer #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .byte_cnt(byte_cnt), .beat_valid(beat_valid), .beat_ready(beat_ready),
    .beat_addr(beat_addr), .beat_size(beat_size), .done(done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int pick(input logic [AW-1:0] a, input int rem);
    if (a[1:0] == 2'b00 && rem >= 4) return 4;
    if (!a[0] && rem >= 2) return 2;
    return 1;
  endfunction

  function automatic logic [1:0] enc(input int b);
    return (b == 4) ? 2'd2 : ((b == 2) ? 2'd1 : 2'd0);
  endfunction

  // stall = 0: sink always ready; otherwise low on every stall-th cycle
  task automatic run_copy(input logic [AW-1:0] a, input int n, input int stall,
                          input string req);
    logic [AW-1:0] ma;
    int rem;
    int cyc;
    int b;
    ma = a; rem = n; cyc = 0;
    seq.delete();
    @(negedge clk);
    start_addr = a; byte_cnt = n[CW-1:0]; start = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    while (rem > 0 && cyc < 1000) begin
      b = pick(ma, rem);
      check(beat_valid === 1'b1, req, "beat_valid", beat_valid, 1);
      check(beat_addr === ma, req, "beat_addr (R3/R9)", beat_addr, ma);
      check(beat_size === enc(b), req, "beat_size (R2)", beat_size, enc(b));
      beat_ready = (stall == 0) || (cyc % stall != 0);
      if (beat_ready) begin
        seq.push_back(b);
        ma += AW'(b);
        rem -= b;
      end
      cyc++;
      @(negedge clk);
    end
    beat_ready = 1'b0;
    check(done === 1'b1, req, "done after last beat (R4/R5)", done, 1);
    check(beat_valid === 1'b0, req, "valid low at done (R4)", beat_valid, 0);
    @(negedge clk);
    check(done === 1'b0, req, "done one cycle only (R4)", done, 0);
  endtask

  task automatic t_reset();
    check(beat_valid === 1'b0, "R1", "beat_valid after reset", beat_valid, 0);
    check(done === 1'b0, "R1", "done after reset", done, 0);
  endtask

  task automatic t_example();
    int exp_b[5] = '{1, 2, 4, 2, 1};
    run_copy(32'h1, 10, 0, "R8");
    check(seq.size() == 5, "R8", "beat count", seq.size(), 5);
    for (int i = 0; i < 5; i++)
      if (i < seq.size())
        check(seq[i] == exp_b[i], "R8", "beat bytes", seq[i], exp_b[i]);
  endtask

  task automatic t_restart_busy();
    @(negedge clk);
    start_addr = 32'h100; byte_cnt = 16'd8; start = 1'b1; beat_ready = 1'b0;
    @(negedge clk);
    start_addr = 32'h203; byte_cnt = 16'd1;
    @(negedge clk);
    start = 1'b0;
    check(beat_addr === 32'h100, "R6", "addr after ignored start", beat_addr, 32'h100);
    check(beat_size === 2'd2, "R6", "size after ignored start", beat_size, 2);
    beat_ready = 1'b1;
    @(negedge clk);
    check(beat_addr === 32'h104 && beat_valid === 1'b1, "R6", "second beat addr",
          beat_addr, 32'h104);
    @(negedge clk);
    beat_ready = 1'b0;
    check(done === 1'b1, "R6", "done after original 8 bytes", done, 1);
  endtask

  bit wd_fired = 1'b0;
  initial begin
    #(200000 * 20);
    wd_fired = 1'b1;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_example();
    run_copy(32'h1, 10, 3, "R3");
    run_copy(32'h1000, 0, 0, "R5");
    run_copy(32'h7, 1, 0, "R7");
    run_copy(32'h2, 3, 0, "R7");
    run_copy(32'h40, 16, 0, "R2");
    run_copy(32'h13, 23, 2, "R4");
    run_copy(32'h3FE, 5, 0, "R9");
    t_restart_busy();
    if (!wd_fired) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule